// File: doc/BRIEF.md
# Card Presence Change Tracker

This block follows card presence in a set of card sockets, two by default. Each socket has a pair of card-detect sensors. When a card is fully seated, both sensors read high. When the socket is empty, both read low. While a card is moving in or out, the pair can pass through a mixed value. Any change in the sampled pair raises a status flag. If the new value also differs from the last accepted value, a pending event is queued for that socket.

A per-socket decision stage handles the pending events one per clock, lowest socket first. It compares the live sensor pair, read as a 2-bit number, with the accepted value. A larger value counts as an insertion and a smaller value counts as a removal. A busy flag per socket makes sure each card produces exactly one attach pulse and one detach pulse. Because the decision is made after the change indication, a half-settled sensor pair does not cause a wrong or duplicated action.

Five further per-socket change inputs feed the same status register: two battery-voltage inputs, ready/busy, write-protect and access-timeout. They raise the interrupt line but never touch presence tracking. Software acknowledges flags by writing ones to the status bits it wants to clear.

Top module: `cd_tracker`

## Requirements
- R1: While `rstN` is low at a clock edge, the block clears all state. After that edge, `attach`, `detach`, `statusReg` and `irq` all read zero.
- R2: The first clock edge with `rstN` high is the start-up edge. At that edge, each socket's sensor pair is taken as its accepted value. A socket with a nonzero pair becomes busy, and its `attach` bit pulses for one cycle after that edge. No flag is set and no event is queued at the start-up edge.
- R3: After start-up, a clock edge at which a socket's sensor pair (`sense[2s+1:2s]`) differs from its value at the previous edge sets that socket's card-detect flag, `statusReg[6s]`.
- R4: Such a change queues an event only if the new pair differs from the accepted value. One queued event is serviced per clock edge, starting at the edge after the event is queued, lowest socket index first. The servicing edge reloads the accepted value from the live pair. Any pulse it causes is visible in the cycle after that edge.
- R5: At service, a live pair numerically greater than the accepted value is an insertion. If the socket is not busy, it becomes busy and `attach[s]` pulses.
- R6: At service, a live pair numerically smaller than the accepted value is a removal. If the socket is busy, it becomes idle and `detach[s]` pulses.
- R7: A card that passes through a partial sensor value produces only one attach, or only one detach, because the busy flag blocks repeats.
- R8: A serviced event whose live pair equals the accepted value produces no pulse.
- R9: A one-cycle pulse on `auxChg[5s+k]` (k = 0..4) sets `statusReg[6s+1+k]` and raises `irq`. It never causes `attach` or `detach`.
- R10: With `ackWe` high, every `ackData` bit that is 1 clears the matching `statusReg` bit, so all ones clears every flag. A flag set at the same edge stays set.
- R11: `irq` is high exactly when at least one `statusReg` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| sense | input | 2*NSOCK | Sensor pairs, socket s at bits 2s+1:2s |
| auxChg | input | 5*NSOCK | One-cycle change pulses, socket s at bits 5s+4:5s |
| ackWe | input | 1 | Status acknowledge strobe |
| ackData | input | 6*NSOCK | Write-one-to-clear mask for statusReg |
| attach | output | NSOCK | One-cycle card attach pulses |
| detach | output | NSOCK | One-cycle card detach pulses |
| statusReg | output | 6*NSOCK | Per-socket flags: bit 0 card detect, bits 1..5 aux changes |
| irq | output | 1 | Status interrupt request |

## Verification
A sensor or aux change presented before edge k appears in `statusReg` and `irq` right after edge k. The queued event for that change is serviced at edge k+1 at the earliest, so its attach or detach pulse appears one cycle after the flag. It appears later still when a lower-numbered socket is also pending. The start-up attach follows the first edge after reset is released.

The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares every output on the next falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/cd_tracker_pkg.sv
package cd_tracker_pkg;
  localparam int SENSE_W = 2;
  localparam int NAUX    = 5;
  localparam int NFLAG   = NAUX + 1;
  localparam int CD_BIT  = 0;

  typedef struct packed {
    logic initLoad;
    logic svcTake;
  } dpCtl_t;
endpackage

// File: rtl/cd_tracker_datapath.sv
module cd_tracker_datapath
  import cd_tracker_pkg::*;
#(
  parameter int NSOCK = 2,
  parameter int IDXW  = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NSOCK*SENSE_W-1:0] sense,
  input  logic [NSOCK*NAUX-1:0]    auxChg,
  input  logic                     ackWe,
  input  logic [NSOCK*NFLAG-1:0]   ackData,
  input  dpCtl_t                   ctl,
  input  logic [IDXW-1:0]          svcIdx,
  output logic [NSOCK-1:0]         pending,
  output logic                     svcGt,
  output logic                     svcLt,
  output logic [NSOCK-1:0]         liveNz,
  output logic [NSOCK*NFLAG-1:0]   statusReg,
  output logic                     irq
);
  logic [SENSE_W-1:0] curArr [NSOCK];
  logic [SENSE_W-1:0] accArr [NSOCK];

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    logic [SENSE_W-1:0] prevVal;
    logic [SENSE_W-1:0] accVal;
    logic               pendBit;
    logic [NFLAG-1:0]   flags;
    logic               edgeSeen;
    logic               queueReq;
    logic               takeMe;
    logic [NFLAG-1:0]   setVec;
    logic [NFLAG-1:0]   clrVec;

    assign curArr[s] = sense[s*SENSE_W +: SENSE_W];
    assign accArr[s] = accVal;
    assign liveNz[s] = |curArr[s];
    assign edgeSeen  = !ctl.initLoad && (curArr[s] != prevVal);
    assign queueReq  = edgeSeen && (curArr[s] != accVal);
    assign takeMe    = ctl.svcTake && (svcIdx == IDXW'(s));
    assign setVec    = {auxChg[s*NAUX +: NAUX], edgeSeen};
    assign clrVec    = ackWe ? ackData[s*NFLAG +: NFLAG] : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevVal <= '0;
        accVal  <= '0;
        pendBit <= 1'b0;
        flags   <= '0;
      end else begin
        prevVal <= curArr[s];
        if (ctl.initLoad || takeMe) accVal <= curArr[s];
        pendBit <= queueReq | (pendBit & ~takeMe);
        flags   <= (flags & ~clrVec) | setVec;
      end
    end

    assign pending[s]                    = pendBit;
    assign statusReg[s*NFLAG +: NFLAG]   = flags;
  end

  assign svcGt = curArr[svcIdx] > accArr[svcIdx];
  assign svcLt = curArr[svcIdx] < accArr[svcIdx];
  assign irq   = |statusReg;
endmodule

// File: rtl/cd_tracker_control.sv
module cd_tracker_control
  import cd_tracker_pkg::*;
#(
  parameter int NSOCK = 2,
  parameter int IDXW  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSOCK-1:0] pending,
  input  logic             svcGt,
  input  logic             svcLt,
  input  logic [NSOCK-1:0] liveNz,
  output dpCtl_t           ctl,
  output logic [IDXW-1:0]  svcIdx,
  output logic [NSOCK-1:0] attach,
  output logic [NSOCK-1:0] detach
);
  logic             initDone;
  logic [NSOCK-1:0] busy;
  logic             found;

  always_comb begin
    found  = 1'b0;
    svcIdx = '0;
    for (int i = 0; i < NSOCK; i++) begin
      if (pending[i] && !found) begin
        found  = 1'b1;
        svcIdx = IDXW'(i);
      end
    end
  end

  assign ctl.initLoad = !initDone;
  assign ctl.svcTake  = initDone && found;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initDone <= 1'b0;
      busy     <= '0;
      attach   <= '0;
      detach   <= '0;
    end else begin
      attach <= '0;
      detach <= '0;
      if (!initDone) begin
        initDone <= 1'b1;
        busy     <= liveNz;
        attach   <= liveNz;
      end else if (found) begin
        if (svcGt && !busy[svcIdx]) begin
          busy[svcIdx]   <= 1'b1;
          attach[svcIdx] <= 1'b1;
        end else if (svcLt && busy[svcIdx]) begin
          busy[svcIdx]   <= 1'b0;
          detach[svcIdx] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cd_tracker.sv
module cd_tracker
  import cd_tracker_pkg::*;
#(
  parameter int NSOCK = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NSOCK*SENSE_W-1:0] sense,
  input  logic [NSOCK*NAUX-1:0]    auxChg,
  input  logic                     ackWe,
  input  logic [NSOCK*NFLAG-1:0]   ackData,
  output logic [NSOCK-1:0]         attach,
  output logic [NSOCK-1:0]         detach,
  output logic [NSOCK*NFLAG-1:0]   statusReg,
  output logic                     irq
);
  localparam int IDXW = (NSOCK > 1) ? $clog2(NSOCK) : 1;

  dpCtl_t           ctl;
  logic [IDXW-1:0]  svcIdx;
  logic [NSOCK-1:0] pending;
  logic [NSOCK-1:0] liveNz;
  logic             svcGt;
  logic             svcLt;

  cd_tracker_datapath #(.NSOCK(NSOCK), .IDXW(IDXW)) u_dp (
    .clk(clk), .rstN(rstN), .sense(sense), .auxChg(auxChg),
    .ackWe(ackWe), .ackData(ackData), .ctl(ctl), .svcIdx(svcIdx),
    .pending(pending), .svcGt(svcGt), .svcLt(svcLt), .liveNz(liveNz),
    .statusReg(statusReg), .irq(irq)
  );

  cd_tracker_control #(.NSOCK(NSOCK), .IDXW(IDXW)) u_ctl (
    .clk(clk), .rstN(rstN), .pending(pending), .svcGt(svcGt),
    .svcLt(svcLt), .liveNz(liveNz), .ctl(ctl), .svcIdx(svcIdx),
    .attach(attach), .detach(detach)
  );
endmodule

// File: rtl/cd_tracker_chk.sv
module cd_tracker_chk
  import cd_tracker_pkg::*;
#(
  parameter int NSOCK = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NSOCK*SENSE_W-1:0] sense,
  input logic [NSOCK*NAUX-1:0]    auxChg,
  input logic [NSOCK-1:0]         attach,
  input logic [NSOCK-1:0]         detach,
  input logic [NSOCK*NFLAG-1:0]   statusReg,
  input logic                     irq,
  input logic                     initDone,
  input logic [NSOCK-1:0]         busy
);
  // R4: after start-up at most one pulse per cycle (one service per clock)
  a_r4_one_service: assert property (@(posedge clk) disable iff (!rstN)
    $past(initDone) |-> ($countones(attach | detach) <= 1));

  // R7: attach and detach never coincide on a socket
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    (attach & detach) == '0);

  for (genvar s = 0; s < NSOCK; s++) begin : g_chk
    // R5: an attach leaves the socket busy
    a_r5_attach_busy: assert property (@(posedge clk) disable iff (!rstN)
      attach[s] |-> busy[s]);
    // R6: a detach leaves the socket idle
    a_r6_detach_idle: assert property (@(posedge clk) disable iff (!rstN)
      detach[s] |-> !busy[s]);
    // R3: a sensor change after start-up sets the card-detect flag
    a_r3_cd_flag: assert property (@(posedge clk) disable iff (!rstN)
      (initDone && sense[s*SENSE_W +: SENSE_W] != $past(sense[s*SENSE_W +: SENSE_W]))
      |=> statusReg[s*NFLAG + CD_BIT]);
    for (genvar k = 0; k < NAUX; k++) begin : g_aux
      // R9: an aux change pulse sets its flag and the interrupt
      a_r9_aux_flag: assert property (@(posedge clk) disable iff (!rstN)
        auxChg[s*NAUX + k] |=> (statusReg[s*NFLAG + 1 + k] && irq));
    end
  end
endmodule

bind cd_tracker cd_tracker_chk #(.NSOCK(NSOCK)) u_chk (
  .clk(clk), .rstN(rstN), .sense(sense), .auxChg(auxChg),
  .attach(attach), .detach(detach), .statusReg(statusReg), .irq(irq),
  .initDone(u_ctl.initDone), .busy(u_ctl.busy)
);

// File: tb/cd_tracker_test.sv
module cd_tracker_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  sense;
  logic [9:0]  auxChg;
  logic        ackWe;
  logic [11:0] ackData;
  logic [1:0]  attach, detach;
  logic [11:0] statusReg;
  logic        irq;

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit started = 0;
  int att1Count = 0;
  int cycles = 0;

  // reference model state
  int          mAcc[2], mPrev[2], mBusy[2], mPend[2];
  logic [5:0]  mFlag[2];
  logic [1:0]  mAtt, mDet;
  bit          mInit;

  cd_tracker uut (
    .clk(clk), .rstN(rstN), .sense(sense), .auxChg(auxChg),
    .ackWe(ackWe), .ackData(ackData), .attach(attach), .detach(detach),
    .statusReg(statusReg), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    int pick;
    int cur;
    int oldAcc[2];
    logic [1:0] na, nd, cdEdge;
    started = 1;
    cycles++;
    if (!rstN) begin
      for (int s = 0; s < 2; s++) begin
        mAcc[s] = 0; mPrev[s] = 0; mBusy[s] = 0; mPend[s] = 0; mFlag[s] = 0;
      end
      mAtt = 0; mDet = 0; mInit = 0;
    end else begin
      na = 0; nd = 0; cdEdge = 0;
      for (int s = 0; s < 2; s++) oldAcc[s] = mAcc[s];
      if (!mInit) begin
        for (int s = 0; s < 2; s++) begin
          cur = int'(sense[2*s +: 2]);
          mAcc[s] = cur; mPrev[s] = cur;
          mBusy[s] = (cur != 0);
          na[s] = (cur != 0);
        end
        mInit = 1;
      end else begin
        pick = -1;
        for (int s = 0; s < 2; s++) if (mPend[s] != 0 && pick < 0) pick = s;
        if (pick >= 0) begin
          cur = int'(sense[2*pick +: 2]);
          if (cur > mAcc[pick]) begin
            if (mBusy[pick] == 0) begin mBusy[pick] = 1; na[pick] = 1; end
          end else if (cur < mAcc[pick]) begin
            if (mBusy[pick] != 0) begin mBusy[pick] = 0; nd[pick] = 1; end
          end
          mAcc[pick] = cur;
          mPend[pick] = 0;
        end
        for (int s = 0; s < 2; s++) begin
          cur = int'(sense[2*s +: 2]);
          if (cur != mPrev[s]) begin
            cdEdge[s] = 1;
            if (cur != oldAcc[s]) mPend[s] = 1;
          end
          mPrev[s] = cur;
        end
      end
      for (int s = 0; s < 2; s++)
        mFlag[s] = (mFlag[s] & ~(ackWe ? ackData[6*s +: 6] : 6'h0)) |
                   {auxChg[5*s +: 5], cdEdge[s]};
      mAtt = na; mDet = nd;
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    logic [11:0] expStat;
    if (started) begin
      expStat = {mFlag[1], mFlag[0]};
      checks++;
      if (attach !== mAtt || detach !== mDet || statusReg !== expStat ||
          irq !== (|expStat)) begin
        fails++;
        $display("FAIL %s actual att=%b det=%b stat=%h irq=%b expected att=%b det=%b stat=%h irq=%b",
                 tag, attach, detach, statusReg, irq, mAtt, mDet, expStat, |expStat);
      end
      if (attach[1] === 1'b1) att1Count++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      auxChg = '0; ackWe = 0; ackData = '0;
    end
  endtask

  task automatic setSock(input int s, input logic [1:0] v);
    @(negedge clk);
    auxChg = '0; ackWe = 0; ackData = '0;
    sense[2*s +: 2] = v;
  endtask

  task automatic ackAll();
    @(negedge clk);
    auxChg = '0; ackWe = 1; ackData = 12'hfff;
  endtask

  task automatic directCheck(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  initial begin
    rstN = 0; sense = 4'b0011; auxChg = '0; ackWe = 0; ackData = '0;
    tag = "R1";
    repeat (3) @(negedge clk);
    directCheck("R1 reset outputs", int'({attach, detach, irq}), 0);
    // R2: start-up with socket0 present, socket1 empty
    tag = "R2";
    rstN = 1;
    idle(3);
    // R3, R7: socket1 partial insertion then full
    tag = "R3";
    att1Count = 0;
    setSock(1, 2'b01);
    idle(2);
    tag = "R7";
    setSock(1, 2'b11);
    idle(3);
    directCheck("R7 single attach on socket1", att1Count, 1);
    // R10: acknowledge everything
    tag = "R10";
    ackAll();
    idle(1);
    directCheck("R10 flags cleared", int'(statusReg), 0);
    // R6: removal of socket0 through a partial value
    tag = "R6";
    setSock(0, 2'b01);
    idle(2);
    setSock(0, 2'b00);
    idle(3);
    // R4: both sockets change in one cycle, socket0 first
    tag = "R4";
    ackAll();
    @(negedge clk);
    ackWe = 0; ackData = '0;
    sense = 4'b0011;
    idle(4);
    // R8: quick glitch returns to accepted value before service
    tag = "R8";
    setSock(0, 2'b10);
    setSock(0, 2'b11);
    idle(3);
    // R9: aux pulses only touch flags
    tag = "R9";
    ackAll();
    @(negedge clk);
    ackWe = 0; ackData = '0; auxChg = 10'b10000_00001;
    @(negedge clk);
    auxChg = 10'b00100_01000;
    idle(2);
    // R10: set wins over a same-cycle acknowledge
    tag = "R10";
    @(negedge clk);
    auxChg = 10'b00000_00001; ackWe = 1; ackData = 12'hfff;
    idle(1);
    directCheck("R10 set beats clear", int'(statusReg), 2);
    // R11: irq follows flags
    tag = "R11";
    ackAll();
    idle(1);
    directCheck("R11 irq low when clear", int'(irq), 0);
    // R5: mixed random stress
    tag = "R5";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      sense   = ($urandom_range(0, 3) == 0) ? 4'($urandom) : sense;
      auxChg  = ($urandom_range(0, 7) == 0) ? 10'($urandom) : '0;
      ackWe   = ($urandom_range(0, 5) == 0);
      ackData = 12'($urandom);
    end
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule